// File: doc/BRIEF.md
# Streaming grayscale top-hat / bottom-hat filter

The block filters an 8-bit grayscale raster that arrives one pixel per clock. It can compute a white top-hat or a black bottom-hat. A white top-hat subtracts the opening from the input, which leaves bright features narrower than the structuring element on a dark background. A black bottom-hat subtracts the input from the closing, which leaves dark features narrower than the element on a bright background. The structuring element is a flat rectangle of `SE_W` x `SE_H` pixels, anchored at its centre.

Each morphological step is split into a row pass and a column pass, so the cost per pixel does not depend on the element size. Every pass is a windowed minimum. A maximum is obtained by complementing the pixels around the same minimum pass, so the datapath has only one kind of comparator. The pipeline has a fixed length. A delay line brings the original pixel, the valid flag and the frame marker into line with the filtered pixel, and the block then subtracts one from the other.

A frame is `IMG_W*IMG_H` valid beats in back-to-back cycles. The first beat carries the start-of-frame flag. Idle cycles of any length, including zero, may separate frames.

Top module: `tophat_filter`

## Requirements
- R1: With `mode_i`=0 (top-hat), each output pixel equals the input pixel minus its opening. The opening is a minimum over the centred `SE_W`x`SE_H` rectangle, followed by a maximum over the same rectangle.
- R2: With `mode_i`=1 (bottom-hat), each output pixel equals the closing minus the input pixel. The closing is a maximum over the rectangle, followed by a minimum over it.
- R3: Neighbours that fall outside the frame count as 255 in a minimum and as 0 in a maximum. A frame of constant value therefore produces all-zero output in both modes, including at the frame edges.
- R4: The mode is captured on the beat that carries `in_sof_i` and applies to the whole frame. Changes on `mode_i` during the rest of the frame have no effect.
- R5: Each output beat appears exactly `2*((SE_W-1)/2 + ((SE_H-1)/2)*IMG_W + 2) + 1` cycles after its input beat. `out_sof_o` marks the first pixel of a frame, and `out_valid_o` repeats the `in_valid_i` pattern.
- R6: The difference is never negative. In top-hat mode the opening never exceeds the input, and in bottom-hat mode the closing never falls below it.
- R7: Frames may follow each other with no idle cycle or with any number of idle cycles, and every frame is filtered without reference to the frame before it.
- R8: While reset is asserted and after it is released, `out_valid_o`, `out_sof_o` and `out_pix_o` are 0 until the first filtered pixel comes out.
- R9: A single bright pixel on a uniform background survives top-hat filtering at full contrast, with zeros elsewhere. A single dark pixel survives bottom-hat filtering in the same way, at the frame corner as well as inside the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = top-hat, 1 = bottom-hat; sampled on the start-of-frame beat |
| in_valid_i | input | 1 | Input pixel valid |
| in_sof_i | input | 1 | First pixel of a frame |
| in_pix_i | input | 8 | Input pixel |
| out_valid_o | output | 1 | Output pixel valid |
| out_sof_o | output | 1 | First output pixel of a frame |
| out_pix_o | output | 8 | Filtered pixel |

## Verification
The bench builds the block with a 10x6 frame and a 5x3 element. Because the row radius differs from the column radius, a swap of the row and column passes changes the result. The element reaches past every edge of the frame, so the border rule is exercised in the corners as well as along each side. A line is only ten pixels long, which keeps the pipeline at 29 cycles. Many random frames, back-to-back frames and frames in which the mode changes during the frame therefore fit in a short run.

// File: rtl/th_pkg.sv
package th_pkg;

  typedef struct packed {
    logic       valid;
    logic       sof;
    logic       bh;     // frame is bottom-hat
    logic [7:0] pix;
  } beat_t;

  typedef struct packed {
    logic       valid;
    logic       sof;
    logic [7:0] pix;
  } tag_t;

  localparam logic [7:0] PIX_NEUTRAL = 8'hFF;  // neutral element of min

  function automatic beat_t flip(beat_t b);
    beat_t r;
    r     = b;
    r.pix = ~b.pix;
    return r;
  endfunction

endpackage

// File: rtl/th_delay.sv
module th_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  if (DEPTH <= 1) begin : g_flop
    logic [WIDTH-1:0] q_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q <= '0;
      else         q_q <= d_i;
    end
    assign q_o = q_q;
  end else begin : g_ring
    localparam int AW = $clog2(DEPTH);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    ptr_q;
    // read-before-write ring: output is the word written DEPTH cycles ago
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q <= '0;
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
        mem_q[ptr_q] <= d_i;
        ptr_q        <= (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
    end
    assign q_o = mem_q[ptr_q];
  end

endmodule

// File: rtl/th_pass.sv
// 1-D windowed minimum along rows (VERT=0) or columns (VERT=1).
module th_pass
  import th_pkg::*;
#(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  parameter int SPAN  = 3,
  parameter bit VERT  = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  beat_t beat_i,
  output beat_t beat_o
);

  localparam int RAD   = (SPAN - 1) / 2;
  localparam int STEP  = VERT ? IMG_W : 1;
  localparam int LIMIT = VERT ? IMG_H : IMG_W;
  localparam int XW    = $clog2(IMG_W + 1);
  localparam int YW    = $clog2(IMG_H + 1);

  beat_t tap [SPAN];
  assign tap[0] = beat_i;

  for (genvar k = 1; k < SPAN; k++) begin : g_tap
    th_delay #(.WIDTH($bits(beat_t)), .DEPTH(STEP)) u_dly (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (tap[k-1]),
      .q_o   (tap[k])
    );
  end

  beat_t ctr;
  assign ctr = tap[RAD];

  // raster position of the centre sample
  logic [XW-1:0] nx_q, cx;
  logic [YW-1:0] ny_q, cy;
  assign cx = ctr.sof ? '0 : nx_q;
  assign cy = ctr.sof ? '0 : ny_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nx_q <= '0;
      ny_q <= '0;
    end else if (ctr.valid) begin
      if (int'(cx) == IMG_W - 1) begin
        nx_q <= '0;
        ny_q <= (int'(cy) == IMG_H - 1) ? '0 : YW'(int'(cy) + 1);
      end else begin
        nx_q <= XW'(int'(cx) + 1);
        ny_q <= cy;
      end
    end
  end

  logic [7:0] win_min;
  always_comb begin
    int pos;
    int p;
    pos     = VERT ? int'(cy) : int'(cx);
    win_min = PIX_NEUTRAL;
    for (int k = 0; k < SPAN; k++) begin
      p = pos + RAD - k;  // tap k holds the neighbour at offset RAD-k
      if (p >= 0 && p < LIMIT && tap[k].pix < win_min) win_min = tap[k].pix;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o <= '0;
    end else begin
      beat_o       <= ctr;
      beat_o.pix   <= ctr.valid ? win_min : '0;
    end
  end

  // R1
  erode_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr.valid |=> (beat_o.pix <= $past(ctr.pix)));

endmodule

// File: rtl/tophat_filter.sv
module tophat_filter
  import th_pkg::*;
#(
  parameter int IMG_W = 320,
  parameter int IMG_H = 240,
  parameter int SE_W  = 3,
  parameter int SE_H  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_i,
  input  logic       in_valid_i,
  input  logic       in_sof_i,
  input  logic [7:0] in_pix_i,
  output logic       out_valid_o,
  output logic       out_sof_o,
  output logic [7:0] out_pix_o
);

  localparam int PIPE_LAT = 2 * ((SE_W - 1) / 2 + ((SE_H - 1) / 2) * IMG_W + 2);

  logic mode_q, frame_bh, sof_beat;
  assign sof_beat = in_valid_i & in_sof_i;
  assign frame_bh = sof_beat ? mode_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= 1'b0;
    else if (sof_beat) mode_q <= mode_i;
  end

  // Bottom-hat enters complemented so stage A (min) acts as dilation.
  // Between stages the data is always complemented: stage B is then the dual op.
  beat_t stg [5];
  assign stg[0] = '{valid: in_valid_i, sof: sof_beat, bh: frame_bh,
                    pix: frame_bh ? ~in_pix_i : in_pix_i};

  for (genvar s = 0; s < 4; s++) begin : g_pass
    localparam bit VERT = (s % 2) == 1;
    beat_t pin;
    assign pin = (s == 2) ? flip(stg[s]) : stg[s];
    th_pass #(
      .IMG_W(IMG_W), .IMG_H(IMG_H),
      .SPAN (VERT ? SE_H : SE_W), .VERT(VERT)
    ) u_pass (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .beat_i(pin),
      .beat_o(stg[s+1])
    );
  end

  beat_t      tail;
  logic [7:0] filt;
  assign tail = stg[4];
  assign filt = tail.bh ? tail.pix : ~tail.pix;

  tag_t tag_in, dly_q;
  assign tag_in = '{valid: in_valid_i, sof: sof_beat, pix: in_pix_i};

  th_delay #(.WIDTH($bits(tag_t)), .DEPTH(PIPE_LAT)) u_align (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tag_in),
    .q_o   (dly_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_sof_o   <= 1'b0;
      out_pix_o   <= '0;
    end else begin
      out_valid_o <= tail.valid;
      out_sof_o   <= tail.sof;
      if (!tail.valid)  out_pix_o <= '0;
      else if (tail.bh) out_pix_o <= filt - dly_q.pix;
      else              out_pix_o <= dly_q.pix - filt;
    end
  end

  // R6
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail.valid |-> (tail.bh ? (filt >= dly_q.pix) : (filt <= dly_q.pix)));

  // R5
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail.valid == dly_q.valid) && (tail.sof == dly_q.sof));

  // R4
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sof_beat |=> $stable(mode_q));

endmodule

// File: tb/sim_tophat_filter.sv
`timescale 1ns/1ps
module sim_tophat_filter;

  localparam int W   = 10;
  localparam int H   = 6;
  localparam int SW  = 5;
  localparam int SH  = 3;
  localparam int N   = W * H;
  localparam int LAT = 2 * ((SW - 1) / 2 + ((SH - 1) / 2) * W + 2) + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic [7:0] in_pix = '0;
  logic       out_valid, out_sof;
  logic [7:0] out_pix;

  always #5 clk = ~clk;

  tophat_filter #(.IMG_W(W), .IMG_H(H), .SE_W(SW), .SE_H(SH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .in_valid_i(in_valid), .in_sof_i(in_sof), .in_pix_i(in_pix),
    .out_valid_o(out_valid), .out_sof_o(out_sof), .out_pix_o(out_pix)
  );

  int    checks = 0;
  int    errors = 0;
  int    bufs [3][N];
  int    exp_q [$];
  bit    sof_q [$];
  string req_q [$];
  time   t_in = 0, t_out = 0;
  bit    seen_in = 0, seen_out = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // full 2-D window with neutral borders
  task automatic morph(input bit dil, input int s, input int d);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        int v;
        v = dil ? 0 : 255;
        for (int dy = -(SH - 1) / 2; dy <= (SH - 1) / 2; dy++)
          for (int dx = -(SW - 1) / 2; dx <= (SW - 1) / 2; dx++) begin
            int yy, xx, t;
            yy = y + dy; xx = x + dx;
            if (yy >= 0 && yy < H && xx >= 0 && xx < W) begin
              t = bufs[s][yy * W + xx];
              if (dil ? (t > v) : (t < v)) v = t;
            end
          end
        bufs[d][y * W + x] = v;
      end
  endtask

  task automatic send_frame(input bit bh, input int kind, input int gap,
                            input bit toggle, input string req);
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: bufs[0][i] = $urandom % 256;
        1: bufs[0][i] = 255;
        2: bufs[0][i] = 0;
        3: bufs[0][i] = (i == 2 * W + 4) ? 200 : 20;
        4: bufs[0][i] = (i == 0) ? 10 : 220;
        default: bufs[0][i] = ($urandom % 8 == 0) ? 150 + $urandom % 100 : $urandom % 40;
      endcase
    end
    morph(bh, 0, 1);
    morph(!bh, 1, 2);
    for (int i = 0; i < N; i++) begin
      exp_q.push_back(bh ? bufs[2][i] - bufs[0][i] : bufs[0][i] - bufs[2][i]);
      sof_q.push_back(i == 0);
      req_q.push_back(req);
    end
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_pix   = 8'(bufs[0][i]);
      mode     = (i == 0 || !toggle) ? bh : 1'($urandom % 2);
      if (i == 0 && !seen_in) begin seen_in = 1; t_in = $time; end
    end
    if (gap > 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      mode     = 1'($urandom % 2);
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected beat", out_pix, -1);
      end else begin
        int    e;
        bit    es;
        string r;
        e = exp_q.pop_front(); es = sof_q.pop_front(); r = req_q.pop_front();
        check(out_pix == 8'(e), r, out_pix, e);
        check(out_sof == es, "R5 sof marker", out_sof, es);
      end
      if (out_sof && !seen_out) begin seen_out = 1; t_out = $time; end
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R8
    check(out_valid == 1'b0 && out_pix == 8'd0 && out_sof == 1'b0, "R8 reset state", out_pix, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R8 idle after reset", out_valid, 0);

    send_frame(1'b0, 0, 3, 1'b0, "R1 random top-hat");
    send_frame(1'b0, 1, 2, 1'b0, "R3 constant 255 top-hat");
    send_frame(1'b1, 2, 1, 1'b0, "R3 constant 0 bottom-hat");
    send_frame(1'b1, 1, 4, 1'b0, "R3 constant 255 bottom-hat");
    send_frame(1'b0, 3, 2, 1'b0, "R9 bright dot top-hat");
    send_frame(1'b1, 4, 0, 1'b0, "R9 dark corner dot bottom-hat");
    send_frame(1'b1, 0, 0, 1'b0, "R2 R7 back-to-back bottom-hat");
    send_frame(1'b0, 5, 1, 1'b0, "R1 sparse bright top-hat");
    send_frame(1'b0, 0, 2, 1'b1, "R4 mode toggles in top-hat frame");
    send_frame(1'b1, 0, 3, 1'b1, "R4 mode toggles in bottom-hat frame");
    for (int f = 0; f < 6; f++)
      send_frame(1'($urandom % 2), (f % 2 == 0) ? 0 : 5, $urandom % 5, 1'b1, "R7 random stream");

    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    repeat (LAT + 5) @(negedge clk);
    // R5
    check(seen_out && (t_out - t_in) / 10 == LAT, "R5 latency",
          int'((t_out - t_in) / 10), LAT);
    check(exp_q.size() == 0, "R5 all beats delivered", exp_q.size(), 0);
    finish_run();
  end

endmodule